// File: doc/BRIEF.md
# Infrared Transmit Frame Header Parser

This block sits between a host bulk-out byte channel and an infrared line encoder. Every frame the host sends opens with a two-byte sync signature (0x55 then 0xAA) and a 16-bit little-endian count of the payload bytes that follow. The parser checks the signature and decodes the count. It removes all header bytes from the stream and forwards exactly the counted number of payload bytes. Each forwarded byte carries start-of-frame, end-of-frame and preamble tags.

In fast infrared mode, a payload must open with a run of exactly sixteen 0x7F characters. These characters tell the encoder to emit the receiver synchronisation preamble. The parser tags the bytes of that run. If the run is too short or too long, it raises a sticky preamble error but still forwards the whole frame. A broken signature raises a sticky header error, and the parser then discards bytes until it sees a new 0x55.

Both byte interfaces are valid/ready. A byte moves when valid and ready are both high at a rising clock edge. Once `out_valid` is high, the output beat and its tags stay stable until `out_ready` accepts them. While the output register holds an unaccepted payload byte, `in_ready` drops for further payload bytes, so nothing is lost. Header bytes never produce output and are taken at any time. The mode pin and both error flags are plain levels.

Top module: `irhp_frame_parser`

## Requirements
- R1: After reset, `out_valid`, `hdr_err` and `pre_err` are 0, `in_ready` is 1, and the parser is searching for a header.
- R2: A frame is 0x55, 0xAA, count low byte, count high byte, then the payload. Header bytes produce no output. Exactly the counted number of payload bytes are forwarded, unchanged and in order, with counts up to 65535.
- R3: `out_sof` is 1 only on the first forwarded byte of a frame, and `out_eof` is 1 only on the byte that brings the remaining count to zero. A frame with a count of one has both tags on its single byte.
- R4: A count of zero forwards nothing and returns the parser to header search, so the next 0x55 opens a frame.
- R5: A first header byte other than 0x55 sets `hdr_err`, and bytes are then dropped until a 0x55 arrives. A second header byte other than 0xAA also sets `hdr_err`. If that second byte is itself 0x55, it is taken as a new first header byte; otherwise the search restarts. `hdr_err` stays set until reset.
- R6: With `fast_mode` = 1, `out_pre` is 1 on the leading 0x7F payload bytes, at most the first 16 of them. With `fast_mode` = 0, `out_pre` is never 1.
- R7: In fast mode, a leading 0x7F run that is not exactly 16 bytes sets `pre_err` and leaves the frame fully forwarded. A 17th 0x7F is forwarded untagged. A frame that ends inside a shorter run, or that opens with a different byte, counts as too short. `pre_err` stays set until reset.
- R8: `fast_mode` is sampled when the count high byte is accepted. Changes during the payload have no effect on that frame.
- R9: While `out_valid` = 1 and `out_ready` = 0, the output beat stays unchanged and payload input is held off. No byte is lost or duplicated.
- R10: With `out_ready` held at 1, one byte is accepted every cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects fast infrared framing with a preamble check |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with `in_valid` |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Forwarded payload byte |
| out_sof | output | 1 | First payload byte of a frame |
| out_eof | output | 1 | Last payload byte of a frame |
| out_pre | output | 1 | Byte belongs to the preamble run |
| hdr_err | output | 1 | Sticky header signature error |
| pre_err | output | 1 | Sticky preamble run length error |

## Verification
Header parsing for the next frame can run in the same cycle that the output register still holds, stalled, the last payload byte of the previous frame. Preamble error detection can also fall on the end-of-frame byte itself. The bench provokes the first case by sending frames back to back while `out_ready` is randomly withheld. It provokes the second with fast frames whose payload is all 0x7F and shorter than sixteen bytes. Every delivered beat is compared against a queue built from the frame description. A stalled beat must reappear unchanged on the next cycle, and after each scenario has drained, the error flags are checked against values the bench derives itself.

// File: rtl/irhp_pkg.sv
package irhp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_HUNT   = 3'd0,
    ST_SIG2   = 3'd1,
    ST_LEN_LO = 3'd2,
    ST_LEN_HI = 3'd3,
    ST_BODY   = 3'd4
  } hp_state_e;

  typedef struct packed {
    byte_t data;
    logic  sof;
    logic  eof;
    logic  pre;
  } beat_t;
endpackage

// File: rtl/irhp_hdr_fsm.sv
module irhp_hdr_fsm
  import irhp_pkg::*;
#(
  parameter byte_t SYNC_A = 8'h55,
  parameter byte_t SYNC_B = 8'hAA
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  acc,
  input  byte_t din,
  output logic  in_body,
  output logic  first_beat,
  output logic  last_beat,
  output logic  frame_start,
  output logic  sync_err
);
  hp_state_e        st_q, st_d;
  byte_t            lo_q, lo_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] len_w;

  assign len_w      = {din, lo_q};
  assign in_body    = (st_q == ST_BODY);
  assign first_beat = in_body && first_q;
  assign last_beat  = in_body && (remain_q == CNT_W'(1));

  always_comb begin
    st_d        = st_q;
    lo_d        = lo_q;
    remain_d    = remain_q;
    first_d     = first_q;
    frame_start = 1'b0;
    sync_err    = 1'b0;
    if (acc) begin
      case (st_q)
        ST_HUNT: begin
          if (din == SYNC_A) st_d = ST_SIG2;
          else               sync_err = 1'b1;
        end
        ST_SIG2: begin
          if (din == SYNC_B) begin
            st_d = ST_LEN_LO;
          end else begin
            sync_err = 1'b1;
            st_d     = (din == SYNC_A) ? ST_SIG2 : ST_HUNT;
          end
        end
        ST_LEN_LO: begin
          lo_d = din;
          st_d = ST_LEN_HI;
        end
        ST_LEN_HI: begin
          if (len_w == '0) begin
            st_d = ST_HUNT;
          end else begin
            st_d        = ST_BODY;
            remain_d    = len_w;
            first_d     = 1'b1;
            frame_start = 1'b1;
          end
        end
        ST_BODY: begin
          remain_d = remain_q - CNT_W'(1);
          first_d  = 1'b0;
          if (remain_q == CNT_W'(1)) st_d = ST_HUNT;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_HUNT;
      lo_q     <= '0;
      remain_q <= '0;
      first_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      lo_q     <= lo_d;
      remain_q <= remain_d;
      first_q  <= first_d;
    end
  end

  // R2: a payload phase always has bytes left to forward
  assert_remain_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_body |-> (remain_q != '0));

  // R3: after the closing byte the parser is back in header search
  assert_eof_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last_beat) |=> (st_q == ST_HUNT));

  // R3: start tag appears only once per frame
  assert_sof_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_body) |=> !first_beat);

  // R4: an empty count never opens a payload phase
  assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (st_q == ST_LEN_HI) && (len_w == '0)) |=> !in_body);
endmodule

// File: rtl/irhp_pre_track.sv
module irhp_pre_track
  import irhp_pkg::*;
#(
  parameter byte_t PRE_CHAR = 8'h7F,
  parameter int    PRE_LEN  = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  fast_in,
  input  logic  acc_body,
  input  logic  last_beat,
  input  byte_t din,
  output logic  tag,
  output logic  run_err
);
  localparam int RC_W = $clog2(PRE_LEN + 1);

  logic            fast_q;
  logic            run_q;
  logic [RC_W-1:0] cnt_q;
  logic            is_pre;
  logic            full;

  assign is_pre = (din == PRE_CHAR);
  assign full   = (cnt_q == RC_W'(PRE_LEN));
  assign tag    = fast_q && run_q && is_pre && !full;

  always_comb begin
    run_err = 1'b0;
    if (acc_body && fast_q && run_q) begin
      if (!is_pre)                                   run_err = !full;
      else if (full)                                 run_err = 1'b1;
      else if (last_beat && (cnt_q != RC_W'(PRE_LEN - 1))) run_err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (frame_start) begin
      fast_q <= fast_in;
      run_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (acc_body) begin
      if (last_beat || !is_pre || full) run_q <= 1'b0;
      else                              cnt_q <= cnt_q + RC_W'(1);
    end
  end

  // R6: the run counter never passes the preamble length
  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RC_W'(PRE_LEN));

  // R8: the mode seen by tagging changes only when a frame opens
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fast_q));

  // R6: slow frames are never tagged
  assert_slow_untagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_q |-> !tag);
endmodule

// File: rtl/irhp_out_reg.sv
module irhp_out_reg
  import irhp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t beat_in,
  input  logic  out_ready,
  output logic  slot_free,
  output logic  out_valid,
  output beat_t beat_out
);
  logic  valid_q;
  beat_t beat_q;

  assign slot_free = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign beat_out  = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      beat_q  <= beat_in;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  // R9: a stalled beat stays put
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(beat_q)));

  // R9: the parser never overwrites an unaccepted beat
  assert_load_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free);
endmodule

// File: rtl/irhp_frame_parser.sv
module irhp_frame_parser
  import irhp_pkg::*;
#(
  parameter byte_t SYNC_A   = 8'h55,
  parameter byte_t SYNC_B   = 8'hAA,
  parameter byte_t PRE_CHAR = 8'h7F,
  parameter int    PRE_LEN  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_pre,
  output logic              hdr_err,
  output logic              pre_err
);
  logic  acc, load, slot_free;
  logic  in_body, first_beat, last_beat, frame_start, sync_err;
  logic  tag, run_err;
  beat_t beat_in, beat_out;
  logic  hdr_err_q, pre_err_q;

  assign in_ready = !in_body || slot_free;
  assign acc      = in_valid && in_ready;
  assign load     = acc && in_body;

  irhp_hdr_fsm #(.SYNC_A(SYNC_A), .SYNC_B(SYNC_B)) u_hdr (
    .clk, .rst_n, .acc, .din(in_data),
    .in_body, .first_beat, .last_beat, .frame_start, .sync_err
  );

  irhp_pre_track #(.PRE_CHAR(PRE_CHAR), .PRE_LEN(PRE_LEN)) u_pre (
    .clk, .rst_n, .frame_start, .fast_in(fast_mode),
    .acc_body(load), .last_beat, .din(in_data),
    .tag, .run_err
  );

  always_comb begin
    beat_in.data = in_data;
    beat_in.sof  = first_beat;
    beat_in.eof  = last_beat;
    beat_in.pre  = tag;
  end

  irhp_out_reg u_out (
    .clk, .rst_n, .load, .beat_in, .out_ready,
    .slot_free, .out_valid, .beat_out
  );

  assign out_data = beat_out.data;
  assign out_sof  = beat_out.sof;
  assign out_eof  = beat_out.eof;
  assign out_pre  = beat_out.pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_err_q <= 1'b0;
      pre_err_q <= 1'b0;
    end else begin
      hdr_err_q <= hdr_err_q | sync_err;
      pre_err_q <= pre_err_q | run_err;
    end
  end

  assign hdr_err = hdr_err_q;
  assign pre_err = pre_err_q;

  // R5: header error is sticky
  assert_hdr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> hdr_err);

  // R7: preamble error is sticky
  assert_pre_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_err |=> pre_err);

  // R9: payload input is held off behind a stalled output beat
  assert_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_body && out_valid && !out_ready) |-> !in_ready);

  // R2: header bytes never produce an output beat
  assert_hdr_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_body && !(out_valid && !out_ready)) |=> !out_valid);
endmodule

// File: tb/irhp_frame_parser_tb.sv
`timescale 1ns/1ps
module irhp_frame_parser_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, fast_mode = 1'b0, in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00, out_data;
  logic out_valid, out_ready, out_sof, out_eof, out_pre, hdr_err, pre_err;

  irhp_frame_parser u_dut (
    .clk, .rst_n, .fast_mode, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .out_sof, .out_eof, .out_pre,
    .hdr_err, .pre_err
  );

  logic [10:0] exp_q[$];
  int checks = 0, fails = 0, mchecks = 0, mfails = 0, rd_idx = 0;
  bit ready_rand = 1'b0, done = 1'b0, exp_pre_err = 1'b0;
  int stalls = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // output monitor: owns out_ready, compares every delivered beat
  bit held = 1'b0;
  logic [10:0] held_v = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 1'b1;
      held = 1'b0;
    end else begin
      if (held) begin
        mchecks++;
        if (!out_valid || {out_data, out_sof, out_eof, out_pre} != held_v) begin
          mfails++;
          $display("FAIL R9 stalled beat changed actual=%0h expected=%0h",
                   {out_valid, out_data, out_sof, out_eof, out_pre}, {1'b1, held_v});
        end
      end
      out_ready = ready_rand ? (($urandom % 4) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        mchecks++;
        if (rd_idx >= exp_q.size()) begin
          mfails++;
          $display("FAIL R2 unexpected beat actual=%0h expected=none",
                   {out_data, out_sof, out_eof, out_pre});
        end else if ({out_data, out_sof, out_eof, out_pre} != exp_q[rd_idx]) begin
          mfails++;
          $display("FAIL R2,R3,R6 beat %0d actual=%0h expected=%0h", rd_idx,
                   {out_data, out_sof, out_eof, out_pre}, exp_q[rd_idx]);
        end
        rd_idx++;
      end
      held = out_valid && !out_ready;
      held_v = {out_data, out_sof, out_eof, out_pre};
    end
  end

  // called at a falling edge, returns at a falling edge after acceptance
  task automatic send_byte(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) break;
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input bit fast, input int n, input int lead, input bit flip);
    int run;
    fast_mode = fast;
    send_byte(8'h55);
    send_byte(8'hAA);
    send_byte(n[7:0]);
    send_byte(n[15:8]);
    if (flip) fast_mode = !fast;
    run = (lead < n) ? lead : n;
    if (fast && n > 0 && run != 16) exp_pre_err = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = $urandom % 256;
      if (i < run) b = 8'h7F;
      else if (b == 8'h7F) b = 8'h00;
      exp_q.push_back({b, i == 0, i == n - 1, fast && i < run && i < 16});
      send_byte(b);
    end
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (rd_idx < exp_q.size() && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(rd_idx == exp_q.size(), req, "beats delivered", rd_idx, exp_q.size());
  endtask

  task automatic do_reset();
    ready_rand = 1'b0;
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_pre_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks + mchecks, fails + mfails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(hdr_err == 1'b0 && pre_err == 1'b0, "R1", "flags", {hdr_err, pre_err}, 0);

    // R2, R3, R4, R10 directed with free-flowing output
    stalls = 0;
    send_frame(1'b0, 5, 0, 1'b0);
    send_frame(1'b1, 20, 16, 1'b0);
    send_frame(1'b0, 1, 0, 1'b0);              // R3 single byte: sof and eof
    send_frame(1'b0, 0, 0, 1'b0);              // R4 empty frame
    send_frame(1'b0, 3, 0, 1'b0);
    send_frame(1'b0, 300, 0, 1'b0);            // R2 count high byte used
    send_frame(1'b0, 6, 6, 1'b0);              // R6 slow 0x7F run untagged
    chk(stalls == 0, "R10", "input stalls", stalls, 0);
    drain("R2");
    chk(hdr_err == 1'b0, "R4", "hdr_err after empty frame", hdr_err, 0);
    chk(pre_err == 1'b0, "R7", "pre_err on 16 run", pre_err, 0);

    // R7 preamble length cases
    do_reset();
    send_frame(1'b1, 24, 15, 1'b0);
    drain("R7");
    chk(pre_err == 1'b1, "R7", "short run", pre_err, 1);
    do_reset();
    send_frame(1'b1, 24, 17, 1'b0);
    drain("R7");
    chk(pre_err == 1'b1, "R7", "long run", pre_err, 1);
    do_reset();
    send_frame(1'b1, 10, 10, 1'b0);
    drain("R7");
    chk(pre_err == 1'b1, "R7", "frame ends in run", pre_err, 1);
    do_reset();
    send_frame(1'b1, 16, 16, 1'b0);
    drain("R7");
    chk(pre_err == 1'b0, "R7", "exact run ending frame", pre_err, 0);

    // R5 header error recovery
    do_reset();
    send_byte(8'h12); send_byte(8'hAA); send_byte(8'h34);
    send_frame(1'b0, 4, 0, 1'b0);
    drain("R5");
    chk(hdr_err == 1'b1, "R5", "bad first byte", hdr_err, 1);
    do_reset();
    send_byte(8'h55);
    send_frame(1'b0, 4, 0, 1'b0);
    drain("R5");
    chk(hdr_err == 1'b1, "R5", "second byte 0x55 restart", hdr_err, 1);
    do_reset();
    send_byte(8'h55); send_byte(8'h13);
    send_frame(1'b0, 4, 0, 1'b0);
    drain("R5");
    chk(hdr_err == 1'b1, "R5", "bad second byte", hdr_err, 1);

    // R8 mode flipped during payload
    do_reset();
    send_frame(1'b1, 20, 16, 1'b1);
    send_frame(1'b0, 18, 16, 1'b1);
    drain("R8");
    chk(pre_err == 1'b0, "R8", "pre_err after flips", pre_err, 0);

    // R9 random frames under random back-pressure
    do_reset();
    ready_rand = 1'b1;
    for (int f = 0; f < 40; f++) begin
      int n, lead;
      n = $urandom % 41;
      lead = (($urandom % 2) == 0) ? 16 : ($urandom % (n + 1));
      send_frame(bit'($urandom % 2), n, lead, 1'b0);
    end
    drain("R9");
    chk(pre_err == exp_pre_err, "R9", "pre_err random", pre_err, exp_pre_err);
    chk(hdr_err == 1'b0, "R9", "hdr_err random", hdr_err, 0);
    ready_rand = 1'b0;
    finish_run();
  end
endmodule